// File: doc/BRIEF.md
# Sequential Booth Signed Multiplier

This block multiplies two signed two's-complement operands with one Booth step per clock. A start pulse while the block is idle captures the multiplicand and the multiplier. The multiplier goes into the low end of a working register, with a single zero bit below it and a cleared accumulator field above it. The block also stores the multiplicand and its negation, so later steps only need to choose between them.

On each clock the two lowest bits of the working register choose the step:

- `01` adds the multiplicand into the accumulator field.
- `10` adds the negated multiplicand.
- `00` and `11` leave the accumulator unchanged.

The whole register then shifts right by one, and the accumulator's sign is copied into the top bit. After one step per multiplier bit, the block writes the signed product to its output register and raises `done` for a single cycle.

The operands need no sign conversion before the multiply and the product needs no correction after it. The accumulator carries one sign-guard bit, so that the most negative multiplicand can be negated without overflow. A start request that arrives during a multiply is dropped. The product output holds its value until the next multiply completes.

Top module: `booth_mul_seq`

## Requirements
- R1: `product` equals the signed product of the captured `mcand` and `mplier`, read as two's-complement values, for every combination of operand signs.
- R2: Operands equal to the most negative value (-128), alone or paired with -128 or 127, still give the exact product.
- R3: Multipliers with long runs of ones, long runs of zeros and alternating bit patterns (such as 0xFF, 0x55 and 0xAA) give the exact product.
- R4: The operands are taken only in the accept cycle. Changing `mcand` or `mplier` while `busy` is high does not change the result.
- R5: A start accepted at a clock edge makes `busy` high from that edge for exactly 8 cycles (OP_W cycles).
- R6: `done` is high for exactly one cycle. It rises at the same edge at which `busy` falls, and `product` already holds the new result in that cycle.
- R7: `product` changes only at an edge that raises `done`. It holds its value through idle periods and through the next multiply.
- R8: A `start` that arrives while `busy` is high is ignored. The running multiply finishes with its original operands, and no extra multiply follows it.
- R9: Reset (`rst_n` low) clears `busy`, `done` and `product` to zero.
- R10: A `start` that is present in the cycle where `done` is high is accepted, and `busy` is high again in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a multiply; it is accepted only while idle |
| mcand | input | OP_W (8) | Signed multiplicand |
| mplier | input | OP_W (8) | Signed multiplier |
| busy | output | 1 | High while a multiply is running |
| done | output | 1 | High for one cycle when a new product is presented |
| product | output | 2*OP_W (16) | Signed product, held until the next completion |

## Verification
The bound checker runs on every cycle. It checks these properties:

- the product against the operands that were captured at accept,
- the fixed busy window, measured with its own counter,
- the single-cycle `done` pulse and its alignment with the fall of `busy`,
- the stability of `product` outside completion edges,
- the reset values.

Some behaviours show up only in the bench scenarios:

- the Booth recoding corners, reached only through chosen multiplier bit patterns and the -128 operand,
- operands changing while a multiply is running,
- start requests that arrive while the block is busy,
- a back-to-back restart in the `done` cycle.

For these, the bench's behavioural model makes the decision on every cycle.

// File: rtl/booth_pkg.sv
package booth_pkg;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } booth_state_e;

   typedef enum logic [1:0] {
      STEP_HOLD = 2'd0,
      STEP_ADD  = 2'd1,
      STEP_SUB  = 2'd2
   } booth_step_e;

   // Radix-2 recoding of the lowest bit pair: {current, previous}.
   function automatic booth_step_e recode(input logic [1:0] pair);
      case (pair)
         2'b01:   return STEP_ADD;
         2'b10:   return STEP_SUB;
         default: return STEP_HOLD;
      endcase
   endfunction

endpackage

// File: rtl/booth_recode.sv
module booth_recode
   import booth_pkg::*;
(
   input  logic [1:0]  pair,
   output booth_step_e op
);
   always_comb op = recode(pair);
endmodule

// File: rtl/booth_step.sv
module booth_step
   import booth_pkg::*;
#(
   parameter int OP_W  = 8,
   parameter int ACC_W = OP_W + 1,
   localparam int REG_W = ACC_W + OP_W + 1
) (
   input  logic [REG_W-1:0] reg_in,
   input  logic [ACC_W-1:0] pos_val,
   input  logic [ACC_W-1:0] neg_val,
   output logic [REG_W-1:0] reg_out
);
   booth_step_e        op;
   logic [ACC_W-1:0]   upper;
   logic [ACC_W-1:0]   addend;
   logic [ACC_W-1:0]   sum;

   booth_recode u_rec (
      .pair (reg_in[1:0]),
      .op   (op)
   );

   assign upper = reg_in[REG_W-1 -: ACC_W];

   always_comb begin
      case (op)
         STEP_ADD: addend = pos_val;
         STEP_SUB: addend = neg_val;
         default:  addend = '0;
      endcase
   end

   assign sum = upper + addend;

   // Arithmetic right shift of {sum, multiplier field, appended bit}.
   assign reg_out = {sum[ACC_W-1], sum, reg_in[OP_W:1]};
endmodule

// File: rtl/booth_ctrl.sv
module booth_ctrl
   import booth_pkg::*;
#(
   parameter int OP_W = 8,
   localparam int CNT_W = $clog2(OP_W + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic load,
   output logic step,
   output logic finish,
   output logic busy,
   output logic done
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(OP_W - 1);

   booth_state_e      state;
   logic [CNT_W-1:0]  cnt;

   assign load   = (state == ST_IDLE) && start;
   assign step   = (state == ST_RUN);
   assign finish = step && (cnt == LAST);
   assign busy   = step;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         cnt   <= '0;
         done  <= 1'b0;
      end else begin
         done <= finish;
         case (state)
            ST_IDLE: begin
               if (start) begin
                  state <= ST_RUN;
                  cnt   <= '0;
               end
            end
            ST_RUN: begin
               if (cnt == LAST) state <= ST_IDLE;
               else             cnt   <= cnt + 1'b1;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/booth_mul_seq.sv
module booth_mul_seq #(
   parameter int OP_W      = 8,
   parameter int GUARD_BIT = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [OP_W-1:0]   mcand,
   input  logic [OP_W-1:0]   mplier,
   output logic              busy,
   output logic              done,
   output logic [2*OP_W-1:0] product
);
   localparam int ACC_W  = OP_W + GUARD_BIT;
   localparam int REG_W  = ACC_W + OP_W + 1;
   localparam int PROD_W = 2 * OP_W;

   if (OP_W < 2) begin : g_bad_width
      $error("booth_mul_seq: OP_W must be at least 2");
   end
   if (GUARD_BIT != 0 && GUARD_BIT != 1) begin : g_bad_guard
      $error("booth_mul_seq: GUARD_BIT must be 0 or 1");
   end

   logic              load, step, finish;
   logic [REG_W-1:0]  work_q, step_out;
   logic [ACC_W-1:0]  pos_q, neg_q, pos_ext, neg_ext;
   logic [PROD_W-1:0] product_q;
   logic              unused_bits;

   // Multiplicand, widened to the accumulator field.
   if (GUARD_BIT == 1) begin : g_guard
      assign pos_ext = {mcand[OP_W-1], mcand};
   end else begin : g_noguard
      assign pos_ext = mcand;
   end
   assign neg_ext = ~pos_ext + 1'b1;

   booth_ctrl #(.OP_W(OP_W)) u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .load   (load),
      .step   (step),
      .finish (finish),
      .busy   (busy),
      .done   (done)
   );

   booth_step #(.OP_W(OP_W), .ACC_W(ACC_W)) u_step (
      .reg_in  (work_q),
      .pos_val (pos_q),
      .neg_val (neg_q),
      .reg_out (step_out)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         work_q    <= '0;
         pos_q     <= '0;
         neg_q     <= '0;
         product_q <= '0;
      end else begin
         if (load) begin
            work_q <= {{ACC_W{1'b0}}, mplier, 1'b0};
            pos_q  <= pos_ext;
            neg_q  <= neg_ext;
         end else if (step) begin
            work_q <= step_out;
         end
         if (finish) product_q <= step_out[PROD_W:1];
      end
   end

   assign unused_bits = ^{step_out[REG_W-1], step_out[0]};
   assign product     = product_q;
endmodule

// File: rtl/booth_mul_chk.sv
module booth_mul_chk #(
   parameter int OP_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [OP_W-1:0]   mcand,
   input logic [OP_W-1:0]   mplier,
   input logic              busy,
   input logic              done,
   input logic [2*OP_W-1:0] product
);
   localparam int RC_W = $clog2(OP_W + 1) + 1;

   logic [OP_W-1:0]          a_q, b_q;
   logic [RC_W-1:0]          run_cnt;
   logic signed [2*OP_W-1:0] expect_w;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q     <= '0;
         b_q     <= '0;
         run_cnt <= '0;
      end else begin
         if (start && !busy) begin
            a_q <= mcand;
            b_q <= mplier;
         end
         run_cnt <= busy ? run_cnt + 1'b1 : '0;
      end
   end

   assign expect_w = $signed(a_q) * $signed(b_q);

   p_value_r1: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (product == expect_w));

   p_busy_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (run_cnt < RC_W'(OP_W)));

   p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (run_cnt == RC_W'(OP_W)));

   p_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_busy_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $fell(busy));

   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(product));

   always @(posedge clk) begin
      if (!rst_n) begin
         a_reset_r9: assert (!busy && !done && product == '0);
      end
   end
endmodule

bind booth_mul_seq booth_mul_chk #(.OP_W(OP_W)) u_chk (.*);

// File: tb/sim_booth_mul_seq.sv
`timescale 1ns/1ps
module sim_booth_mul_seq;
   localparam int W = 8;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           start = 1'b0;
   logic [W-1:0]   mcand = '0, mplier = '0;
   logic           busy, done;
   logic [2*W-1:0] product;

   int checks = 0, errors = 0, cycles = 0;
   bit finished = 0;

   always #10 clk = ~clk;   // 50 MHz

   booth_mul_seq u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .mcand(mcand),
      .mplier(mplier), .busy(busy), .done(done), .product(product)
   );

   // Behavioural reference model
   bit             m_busy, m_done;
   int             m_cnt, m_a, m_b;
   logic [2*W-1:0] m_prod;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_busy <= 0; m_done <= 0; m_cnt <= 0; m_prod <= '0; m_a <= 0; m_b <= 0;
      end else begin
         m_done <= 0;
         if (!m_busy) begin
            if (start) begin
               m_busy <= 1; m_cnt <= 0;
               m_a <= int'($signed(mcand)); m_b <= int'($signed(mplier));
            end
         end else if (m_cnt == W - 1) begin
            m_busy <= 0; m_done <= 1;
            m_prod <= 16'(m_a * m_b);
         end else begin
            m_cnt <= m_cnt + 1;
         end
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      cycles++;
      if (rst_n && !finished) begin
         check(busy == m_busy, "R5", "busy vs model", busy, m_busy);
         check(done == m_done, "R6", "done vs model", done, m_done);
         check(product == m_prod, "R7", "product vs model", product, m_prod);
      end
   end

   task automatic wait_done(input string req);
      for (int k = 0; k < 20; k++) begin
         @(negedge clk);
         if (done) return;
      end
      check(0, req, "done never seen", 0, 1);
   endtask

   task automatic run_mul(input int a, input int b, input string req);
      @(negedge clk);
      start = 1; mcand = W'(a); mplier = W'(b);
      @(negedge clk);
      start = 0;
      wait_done(req);
      check($signed(product) == a * b, req, "product", $signed(product), a * b);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(busy == 0 && done == 0 && product == 0, "R9", "reset state",
            {busy, done, product}, 0);
      rst_n = 1;

      // R1: all sign combinations
      run_mul(10, 2, "R1");
      run_mul(2, 10, "R1");
      run_mul(5, 20, "R1");
      run_mul(-10, 2, "R1");
      run_mul(2, -10, "R1");
      run_mul(-2, -10, "R1");
      run_mul(-10, -2, "R1");
      run_mul(0, -77, "R1");
      // R2: extreme magnitudes
      run_mul(-128, -128, "R2");
      run_mul(-128, 127, "R2");
      run_mul(127, -128, "R2");
      run_mul(127, 127, "R2");
      run_mul(-128, 1, "R2");
      // R3: multiplier bit patterns
      run_mul(-1, -1, "R3");
      run_mul(37, -1, "R3");
      run_mul(-3, 85, "R3");
      run_mul(-7, -86, "R3");
      run_mul(99, 0, "R3");
      run_mul(-55, 112, "R3");

      // R4: operands changed mid-run without start
      @(negedge clk); start = 1; mcand = 8'd9; mplier = 8'd11;
      @(negedge clk); start = 0; mcand = 8'd50; mplier = 8'hC0;
      wait_done("R4");
      check($signed(product) == 99, "R4", "operands captured at accept", $signed(product), 99);

      // R7: product holds while idle
      repeat (5) @(negedge clk);
      check($signed(product) == 99, "R7", "held while idle", $signed(product), 99);

      // R8: start while busy ignored
      @(negedge clk); start = 1; mcand = 8'd3; mplier = 8'd5;
      @(negedge clk); mcand = 8'd100; mplier = 8'd100;
      repeat (4) @(negedge clk);
      start = 0;
      wait_done("R8");
      check($signed(product) == 15, "R8", "start during busy ignored", $signed(product), 15);
      repeat (3) @(negedge clk);
      check(busy == 0, "R8", "no extra multiply", busy, 0);

      // R10: start held through the done cycle restarts at once
      @(negedge clk); start = 1; mcand = 8'd6; mplier = 8'd7;
      wait_done("R10");
      check($signed(product) == 42, "R10", "first of pair", $signed(product), 42);
      mcand = 8'hF7; mplier = 8'd11;   // -9 * 11
      @(negedge clk);
      start = 0;
      check(busy == 1, "R10", "re-accepted in done cycle", busy, 1);
      wait_done("R10");
      check($signed(product) == -99, "R10", "second of pair", $signed(product), -99);

      // R9: reset mid-run clears outputs
      @(negedge clk); start = 1; mcand = 8'd4; mplier = 8'd4;
      @(negedge clk); start = 0;
      repeat (3) @(negedge clk);
      rst_n = 0;
      #1;
      check(busy == 0 && done == 0 && product == 0, "R9", "reset mid-run",
            {busy, done, product}, 0);
      @(negedge clk); rst_n = 1;
      run_mul(-12, 12, "R1");

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   always @(posedge clk) begin
      if (cycles > 100000 && !finished) begin
         finished = 1;
         checks++; errors++;
         $display("FAIL R5 watchdog expired actual=%0d expected=%0d", cycles, 100000);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule